// File: doc/BRIEF.md
# Pipelined Motion Compensation Predictor

This block forms the prediction for one 8x8 pixel block of a video decoder. It reads reference rows from an external row buffer, one forward and one backward row per read. It applies half-pel interpolation separately on each direction, and optionally averages the two directions. It emits the block as a stream of 4-pixel groups, two groups per row. A single start pulse launches a block. The prediction mode and the four half-pel flags are sampled with that pulse.

Each direction has its own path: a pair of row holders (the current row and the row below it), a 5-pixel window register (4 pixels plus the right neighbour) and an interpolation register. A shared output stage then selects or averages the two directions. There are four stages: row load, window load, spatial interpolation, then direction combine. A new row costs two idle issue cycles, so each row takes four cycles.

Top module: `mcp_predictor`

## Requirements
- R1: While reset is held and right after it is released, `out_valid`, `block_done` and `row_rd` are low.
- R2: `start` is taken only when the block is idle and `mode` is 01 (forward), 10 (backward) or 11 (bidirectional). A start with mode 00 is ignored. A start during a block is ignored, and the mode and flags sampled at the accepted start stay in force.
- R3: Row reads: `row_rd` is high with `row_sel`=0 in the cycle after the accepted start, then with `row_sel`=r+1 in cycle 2+4r (r=0..7), nine reads in all. A row is 9 pixels, pixel k at bits [8k+7:8k] of `fwd_row`/`bwd_row`. The row is read combinationally in the `row_rd` cycle.
- R4: Counting the accepted start cycle as 0, the groups of row r appear in cycles 7+4r (columns 0..3) and 8+4r (columns 4..7). This gives two valid cycles and then a two-cycle gap. Group pixel i is at bits [8i+7:8i] of `out_pix`.
- R5: With both flags of a direction clear, its prediction for pixel (r,j) is the reference pixel (r,j).
- R6: With only the horizontal flag set, the prediction is (P[r][j]+P[r][j+1]+1)>>1.
- R7: With only the vertical flag set, the prediction is (P[r][j]+P[r+1][j]+1)>>1, using reference row r+1.
- R8: With both flags set, the prediction is (P[r][j]+P[r][j+1]+P[r+1][j]+P[r+1][j+1]+2)>>2.
- R9: Mode 01 outputs the forward prediction and mode 10 the backward one. The other direction's data and flags have no effect.
- R10: Mode 11 outputs (F+B+1)>>1 of the two direction predictions, per pixel.
- R11: `block_done` is a single-cycle pulse in the cycle after the last group of row 7, which is cycle 37.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one block |
| mode | input | 2 | 01 forward, 10 backward, 11 bidirectional |
| fwd_hx | input | 1 | Forward horizontal half-pel |
| fwd_hy | input | 1 | Forward vertical half-pel |
| bwd_hx | input | 1 | Backward horizontal half-pel |
| bwd_hy | input | 1 | Backward vertical half-pel |
| fwd_row | input | 72 | Forward reference row, 9 pixels |
| bwd_row | input | 72 | Backward reference row, 9 pixels |
| row_rd | output | 1 | Row read strobe |
| row_sel | output | 4 | Row index being read |
| out_valid | output | 1 | Output group valid |
| out_pix | output | 32 | Four predicted pixels |
| block_done | output | 1 | End-of-block pulse |

## Verification
The bench sweeps every mode with all sixteen combinations of forward and backward half-pel flags. It uses data that includes 0/255 checkerboards, so a 9- or 10-bit sum that is truncated, or a missing rounding constant, shows up as wrong pixels. A design that used the wrong row below for vertical interpolation, or swapped the two groups, would give mismatches in specific rows or columns. Off-by-one errors in the pipeline or the row counter move the group cycles, the read sequence or the done cycle. A start during a busy block or with mode 00 must leave the output stream unchanged.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  localparam int PW = 8;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_FWD  = 2'b01,
    MODE_BWD  = 2'b10,
    MODE_BI   = 2'b11
  } pred_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_PRIME, SQ_LOAD, SQ_GAP, SQ_EMIT
  } seq_state_e;

  function automatic logic [PW-1:0] avg2(input logic [PW-1:0] a, input logic [PW-1:0] b);
    logic [PW:0] s;
    s = {1'b0, a} + {1'b0, b} + {{PW{1'b0}}, 1'b1};
    return s[PW:1];
  endfunction

  function automatic logic [PW-1:0] avg4(input logic [PW-1:0] a, input logic [PW-1:0] b,
                                         input logic [PW-1:0] c, input logic [PW-1:0] d);
    logic [PW+1:0] s;
    s = {2'b00, a} + {2'b00, b} + {2'b00, c} + {2'b00, d} + {{PW{1'b0}}, 2'b10};
    return s[PW+1:2];
  endfunction

  function automatic logic [PW-1:0] half_pel(input logic [PW-1:0] a, input logic [PW-1:0] b,
                                             input logic [PW-1:0] c, input logic [PW-1:0] d,
                                             input logic hx, input logic hy);
    case ({hy, hx})
      2'b01:   return avg2(a, b);
      2'b10:   return avg2(a, c);
      2'b11:   return avg4(a, b, c, d);
      default: return a;
    endcase
  endfunction
endpackage

// File: rtl/mcp_seq.sv
module mcp_seq
  import mcp_pkg::*;
#(
  parameter int BLK = 8,
  parameter int GRP = 4,
  localparam int NGRP = BLK / GRP,
  localparam int RW = $clog2(BLK + 1),
  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode_in,
  output logic          accept,
  output logic          row_rd,
  output logic [RW-1:0] row_sel,
  output logic          load_top,
  output logic          load_bot,
  output logic          issue,
  output logic [GW-1:0] grp_idx,
  output logic          grp_last,
  output logic          blk_last,
  output pred_mode_e    mode_q
);
  seq_state_e    state;
  logic [RW-1:0] row;
  logic [GW-1:0] grp;

  assign accept   = (state == SQ_IDLE) && start && (mode_in != 2'b00);
  assign load_top = (state == SQ_PRIME);
  assign load_bot = (state == SQ_LOAD);
  assign row_rd   = load_top || load_bot;
  assign row_sel  = load_top ? '0 : row + RW'(1);
  assign issue    = (state == SQ_EMIT);
  assign grp_idx  = grp;
  assign grp_last = issue && (grp == GW'(NGRP - 1));
  assign blk_last = grp_last && (row == RW'(BLK - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      row    <= '0;
      grp    <= '0;
      mode_q <= MODE_NONE;
    end else begin
      case (state)
        SQ_IDLE: if (accept) begin
          state  <= SQ_PRIME;
          mode_q <= pred_mode_e'(mode_in);
          row    <= '0;
          grp    <= '0;
        end
        SQ_PRIME: state <= SQ_LOAD;
        SQ_LOAD:  state <= SQ_GAP;
        SQ_GAP:   state <= SQ_EMIT;
        SQ_EMIT: begin
          if (grp == GW'(NGRP - 1)) begin
            grp <= '0;
            if (row == RW'(BLK - 1)) state <= SQ_IDLE;
            else begin
              row   <= row + RW'(1);
              state <= SQ_LOAD;
            end
          end else begin
            grp <= grp + GW'(1);
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R2
  mode_none_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_IDLE && start && mode_in == 2'b00) |=> (state == SQ_IDLE));

  // R2
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SQ_IDLE && start) |=> (state != SQ_PRIME));

  // R3
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_rd |-> (row_sel <= RW'(BLK)));
endmodule

// File: rtl/mcp_path.sv
module mcp_path
  import mcp_pkg::*;
#(
  parameter int PIX_W = PW,
  parameter int BLK = 8,
  parameter int GRP = 4,
  localparam int NGRP = BLK / GRP,
  localparam int ROW_W = (BLK + 1) * PIX_W,
  localparam int WIN_W = (GRP + 1) * PIX_W,
  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROW_W-1:0]     row_in,
  input  logic                 load_top,
  input  logic                 load_bot,
  input  logic                 issue,
  input  logic [GW-1:0]        grp_idx,
  input  logic                 shift,
  input  logic                 hx,
  input  logic                 hy,
  input  logic                 win_v,
  output logic [GRP*PIX_W-1:0] pred
);
  logic [ROW_W-1:0]     top_row, bot_row;
  logic [WIN_W-1:0]     win_top, win_bot;
  logic                 win_hx, win_hy;
  logic [WIN_W-1:0]     cand_top [NGRP];
  logic [WIN_W-1:0]     cand_bot [NGRP];
  logic [GRP*PIX_W-1:0] interp_c;

  for (genvar g = 0; g < NGRP; g++) begin : g_cand
    assign cand_top[g] = top_row[g*GRP*PIX_W +: WIN_W];
    assign cand_bot[g] = bot_row[g*GRP*PIX_W +: WIN_W];
  end

  for (genvar i = 0; i < GRP; i++) begin : g_px
    assign interp_c[i*PIX_W +: PIX_W] = half_pel(
      win_top[i*PIX_W +: PIX_W], win_top[(i+1)*PIX_W +: PIX_W],
      win_bot[i*PIX_W +: PIX_W], win_bot[(i+1)*PIX_W +: PIX_W], win_hx, win_hy);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_row <= '0;
      bot_row <= '0;
      win_top <= '0;
      win_bot <= '0;
      win_hx  <= 1'b0;
      win_hy  <= 1'b0;
      pred    <= '0;
    end else begin
      if (load_top)   top_row <= row_in;
      else if (shift) top_row <= bot_row;
      if (load_bot)   bot_row <= row_in;
      if (issue) begin
        win_top <= cand_top[grp_idx];
        win_bot <= cand_bot[grp_idx];
        win_hx  <= hx;
        win_hy  <= hy;
      end
      if (win_v) pred <= interp_c;
    end
  end

  logic [PIX_W-1:0] w_a0, w_b0, p0;
  assign w_a0 = win_top[PIX_W-1:0];
  assign w_b0 = win_top[2*PIX_W-1:PIX_W];
  assign p0   = pred[PIX_W-1:0];

  // R5
  full_pel_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_v && !win_hx && !win_hy) |=> (p0 == $past(w_a0)));

  // R6
  h_half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_v && win_hx && !win_hy) |=>
      (p0 >= (($past(w_a0) < $past(w_b0)) ? $past(w_a0) : $past(w_b0))) &&
      (p0 <= (($past(w_a0) > $past(w_b0)) ? $past(w_a0) : $past(w_b0))));
endmodule

// File: rtl/mcp_avg.sv
module mcp_avg
  import mcp_pkg::*;
#(
  parameter int PIX_W = PW,
  parameter int GRP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  pred_mode_e           mode,
  input  logic [GRP*PIX_W-1:0] fwd,
  input  logic [GRP*PIX_W-1:0] bwd,
  output logic [GRP*PIX_W-1:0] out_pix
);
  logic [GRP*PIX_W-1:0] mix_c;

  for (genvar i = 0; i < GRP; i++) begin : g_mix
    always_comb begin
      case (mode)
        MODE_BWD: mix_c[i*PIX_W +: PIX_W] = bwd[i*PIX_W +: PIX_W];
        MODE_BI:  mix_c[i*PIX_W +: PIX_W] = avg2(fwd[i*PIX_W +: PIX_W], bwd[i*PIX_W +: PIX_W]);
        default:  mix_c[i*PIX_W +: PIX_W] = fwd[i*PIX_W +: PIX_W];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  out_pix <= '0;
    else if (en) out_pix <= mix_c;
  end

  logic [PIX_W-1:0] f0, b0, o0;
  assign f0 = fwd[PIX_W-1:0];
  assign b0 = bwd[PIX_W-1:0];
  assign o0 = out_pix[PIX_W-1:0];

  // R10
  bi_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MODE_BI) |=>
      (o0 >= (($past(f0) < $past(b0)) ? $past(f0) : $past(b0))) &&
      (o0 <= (($past(f0) > $past(b0)) ? $past(f0) : $past(b0))));

  // R9
  bwd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MODE_BWD) |=> (o0 == $past(b0)));
endmodule

// File: rtl/mcp_predictor.sv
module mcp_predictor
  import mcp_pkg::*;
#(
  parameter int PIX_W = PW,
  parameter int BLK = 8,
  parameter int GRP = 4,
  localparam int NGRP = BLK / GRP,
  localparam int ROW_W = (BLK + 1) * PIX_W,
  localparam int RW = $clog2(BLK + 1),
  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int OUT_W = GRP * PIX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             fwd_hx,
  input  logic             fwd_hy,
  input  logic             bwd_hx,
  input  logic             bwd_hy,
  input  logic [ROW_W-1:0] fwd_row,
  input  logic [ROW_W-1:0] bwd_row,
  output logic             row_rd,
  output logic [RW-1:0]    row_sel,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_pix,
  output logic             block_done
);
  logic          accept, load_top, load_bot, issue, grp_last, blk_last;
  logic [GW-1:0] grp_idx;
  pred_mode_e    mode_q;

  mcp_seq #(.BLK(BLK), .GRP(GRP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode),
    .accept(accept), .row_rd(row_rd), .row_sel(row_sel),
    .load_top(load_top), .load_bot(load_bot), .issue(issue),
    .grp_idx(grp_idx), .grp_last(grp_last), .blk_last(blk_last), .mode_q(mode_q)
  );

  logic [1:0] hx_q, hy_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hx_q <= '0;
      hy_q <= '0;
    end else if (accept) begin
      hx_q <= {bwd_hx, fwd_hx};
      hy_q <= {bwd_hy, fwd_hy};
    end
  end

  pred_mode_e s2_mode, s3_mode;
  logic       s2_v, s2_last, s3_v, s3_last, out_last;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_last <= 1'b0; s2_mode <= MODE_NONE;
      s3_v <= 1'b0; s3_last <= 1'b0; s3_mode <= MODE_NONE;
      out_valid <= 1'b0; out_last <= 1'b0; block_done <= 1'b0;
    end else begin
      s2_v       <= issue;
      s2_last    <= blk_last;
      s2_mode    <= mode_q;
      s3_v       <= s2_v;
      s3_last    <= s2_last;
      s3_mode    <= s2_mode;
      out_valid  <= s3_v;
      out_last   <= s3_v && s3_last;
      block_done <= out_valid && out_last;
    end
  end

  logic [ROW_W-1:0] row_in [2];
  logic [OUT_W-1:0] pred   [2];
  assign row_in[0] = fwd_row;
  assign row_in[1] = bwd_row;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    mcp_path #(.PIX_W(PIX_W), .BLK(BLK), .GRP(GRP)) u_path (
      .clk(clk), .rst_n(rst_n), .row_in(row_in[d]),
      .load_top(load_top), .load_bot(load_bot), .issue(issue),
      .grp_idx(grp_idx), .shift(grp_last), .hx(hx_q[d]), .hy(hy_q[d]),
      .win_v(s2_v), .pred(pred[d])
    );
  end

  mcp_avg #(.PIX_W(PIX_W), .GRP(GRP)) u_avg (
    .clk(clk), .rst_n(rst_n), .en(s3_v), .mode(s3_mode),
    .fwd(pred[0]), .bwd(pred[1]), .out_pix(out_pix)
  );

  // R4
  row_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |=> !out_valid);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |=> !block_done);

  // R11
  done_after_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |-> ($past(out_valid) && !out_valid));
endmodule

// File: tb/tb_mcp_predictor.sv
`timescale 1ns/1ps
module tb_mcp_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        fwd_hx = 1'b0, fwd_hy = 1'b0, bwd_hx = 1'b0, bwd_hy = 1'b0;
  logic [71:0] fwd_row, bwd_row;
  logic        row_rd, out_valid, block_done;
  logic [3:0]  row_sel;
  logic [31:0] out_pix;

  int fref [9][9];
  int bref [9][9];
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mcp_predictor dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .fwd_hx(fwd_hx), .fwd_hy(fwd_hy), .bwd_hx(bwd_hx), .bwd_hy(bwd_hy),
    .fwd_row(fwd_row), .bwd_row(bwd_row), .row_rd(row_rd), .row_sel(row_sel),
    .out_valid(out_valid), .out_pix(out_pix), .block_done(block_done)
  );

  always_comb begin
    for (int k = 0; k < 9; k++) begin
      fwd_row[k*8 +: 8] = 8'(fref[(row_sel > 4'd8) ? 8 : int'(row_sel)][k]);
      bwd_row[k*8 +: 8] = 8'(bref[(row_sel > 4'd8) ? 8 : int'(row_sel)][k]);
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int pat(input int p, input int seed, input int dir, input int r, input int k);
    case (p)
      0: return (r * 37 + k * 53 + seed * 11 + dir * 90) % 256;
      1: return (((r + k + dir) % 2) == 1) ? 255 : ((seed % 2 == 1) ? 254 : 0);
      default: return ((r * r * 7 + k * 29 + seed * 13 + dir * 5) ^ (k << 3)) % 256;
    endcase
  endfunction

  function automatic int refpx(input int dir, input int r, input int k);
    return (dir == 0) ? fref[r][k] : bref[r][k];
  endfunction

  // spatial prediction: sum of the used neighbours, divided with round-half-up
  function automatic int spat(input int dir, input int r, input int j, input bit hx, input bit hy);
    int s, n;
    s = refpx(dir, r, j);
    n = 1;
    if (hx) begin s += refpx(dir, r, j + 1); n *= 2; end
    if (hy) begin
      s += refpx(dir, r + 1, j);
      if (hx) s += refpx(dir, r + 1, j + 1);
      n *= 2;
    end
    return (s + n / 2) / n;
  endfunction

  function automatic string flag_tag(input bit hx, input bit hy);
    if (hx && hy) return "R8";
    if (hy)       return "R7";
    if (hx)       return "R6";
    return "R5";
  endfunction

  task automatic run_block(input int m, input bit fhx, input bit fhy, input bit bhx, input bit bhy,
                           input int p, input int seed, input bit inject);
    int got [8][8];
    int vcount, terr, rerr, nreads, dcnt, dk, mism, fa, fe;
    string tag;
    vcount = 0; terr = 0; rerr = 0; nreads = 0; dcnt = 0; dk = -1; mism = 0; fa = 0; fe = 0;
    for (int r = 0; r < 9; r++)
      for (int k = 0; k < 9; k++) begin
        fref[r][k] = pat(p, seed, 0, r, k);
        bref[r][k] = pat(p, seed, 1, r, k);
      end
    @(negedge clk);
    mode = 2'(m); fwd_hx = fhx; fwd_hy = fhy; bwd_hx = bhx; bwd_hy = bhy; start = 1'b1;
    for (int k = 1; k <= 44; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (inject && k == 10) begin
        start = 1'b1; mode = 2'(m ^ 3); fwd_hx = !fhx; fwd_hy = !fhy; bwd_hx = !bhx; bwd_hy = !bhy;
      end
      if (inject && k == 11) start = 1'b0;
      if (row_rd) begin
        nreads++;
        if (k == 1) begin
          if (row_sel != 4'd0) rerr++;
        end else if (k >= 2 && (k - 2) % 4 == 0 && (k - 2) / 4 < 8) begin
          if (int'(row_sel) != (k - 2) / 4 + 1) rerr++;
        end else rerr++;
      end
      if (out_valid) begin
        if (vcount < 16) begin
          if (k != 7 + 4 * (vcount / 2) + (vcount % 2)) terr++;
          for (int i = 0; i < 4; i++)
            got[vcount / 2][4 * (vcount % 2) + i] = int'(out_pix[i*8 +: 8]);
        end
        vcount++;
      end
      if (block_done) begin dcnt++; dk = k; end
    end
    for (int r = 0; r < 8; r++)
      for (int j = 0; j < 8; j++) begin
        int e;
        if (m == 1)      e = spat(0, r, j, fhx, fhy);
        else if (m == 2) e = spat(1, r, j, bhx, bhy);
        else             e = (spat(0, r, j, fhx, fhy) + spat(1, r, j, bhx, bhy) + 1) / 2;
        if (vcount >= 16 && got[r][j] != e) begin
          if (mism == 0) begin fa = got[r][j]; fe = e; end
          mism++;
        end
      end
    chk(vcount == 16 && terr == 0, "R4", "group count/timing errors", vcount * 100 + terr, 1600);
    chk(nreads == 9 && rerr == 0, "R3", "row reads/order errors", nreads * 100 + rerr, 900);
    chk(dcnt == 1 && dk == 37, "R11", "done pulse cycle", dk, 37);
    tag = {(m == 3) ? "R10/" : "R9/", flag_tag((m == 2) ? bhx : fhx, (m == 2) ? bhy : fhy)};
    if (inject) tag = {"R2/", tag};
    chk(mism == 0 && vcount >= 16, tag, "first wrong pixel", fa, fe);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk(!out_valid && !block_done && !row_rd, "R1", "outputs in reset", {out_valid, block_done, row_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !block_done && !row_rd, "R1", "outputs after reset", {out_valid, block_done, row_rd}, 0);

    // R2: mode 00 start must launch nothing
    begin
      int act;
      act = 0;
      mode = 2'b00; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (row_rd || out_valid || block_done) act++;
      end
      chk(act == 0, "R2", "activity after mode 00 start", act, 0);
    end

    cnt = 0;
    for (int m = 1; m <= 3; m++)
      for (int ff = 0; ff < 4; ff++)
        for (int bf = 0; bf < 4; bf++) begin
          run_block(m, ff[0], ff[1], bf[0], bf[1], cnt % 3, cnt, 1'b0);
          cnt++;
        end

    // R2: a start in the middle of a block is ignored
    run_block(3, 1'b1, 1'b0, 1'b0, 1'b1, 1, 7, 1'b1);
    run_block(1, 1'b0, 1'b1, 1'b1, 1'b1, 2, 3, 1'b1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule